// File: doc/BRIEF.md
# Instruction Fetch and Effective Address Sequencer

This block is the front end of a word-addressed accumulator machine. On a start pulse it reads the instruction word at the program counter and splits it into operation, accumulator, indirect, index and address fields. It then advances the program counter. After that it resolves the effective address in a loop. Each pass through the resolve state does at most one step: an index step adds a register, and an indirect step fetches a new address word. When neither step applies, the block presents the final address and the instruction's operation and accumulator fields for one cycle.

Memory is read through a synchronous port with one cycle of latency. Index registers are read through a separate port with the same latency. The accumulators live at the lowest memory locations, so a system may serve both ports from one store. Beside the done pulse, the downstream decoder returns `op_valid`. If it reports that no execution unit takes the operation, the sequencer enters a hang state. It raises `error` and stays there until reset.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is applied and after its release, `done`, `error`, `mem_rd_en` and `reg_rd_en` are low, `pc` equals the parameter `RESET_PC`, and no read is issued until `start` is seen.
- R2: `start` sampled in the idle state makes the next cycle a memory read at `pc`. One cycle after the returned word arrives, `pc` has advanced by one.
- R3: The 36-bit word is split, from the most significant bit down, into the operation (bits 35:27), the accumulator (26:23), the indirect flag (22), the index field (21:18) and the address (17:0).
- R4: An index step reads the register named by the index field and adds the low 18 bits of its contents to the address, modulo 2^18. The step then clears the index field.
- R5: An index field of zero means no indexing, so register 0 is never read.
- R6: An indirect step reads memory at the current address and replaces the indirect flag, the index field and the address with the fetched word's fields. The operation and accumulator keep the values of the original instruction.
- R7: Indexing takes priority over indirection. A word that both indexes and indirects fetches its indirect word at the indexed address.
- R8: `done` is a one-cycle pulse that carries the operation, the accumulator and the effective address. It follows the start sample by 3 + 2·N cycles, where N is the number of index and indirect steps.
- R9: No read is issued in the done cycle. A `start` arriving while an instruction is in progress is ignored.
- R10: If `op_valid` is low in the done cycle, `error` rises on the next cycle and stays high until reset. In that state `start` is ignored and no read is issued.
- R11: The program counter wraps from 2^18−1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin fetching the next instruction (idle state only) |
| op_valid | input | 1 | Decoder accepts the presented operation (sampled with done) |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 18 | Memory read address |
| mem_rd_data | input | 36 | Memory word, valid the cycle after the request |
| reg_rd_en | output | 1 | Index register read request |
| reg_rd_idx | output | 4 | Index register number |
| reg_rd_data | input | 18 | Low 18 bits of that register, valid the cycle after the request |
| pc | output | 18 | Program counter |
| done | output | 1 | Effective address ready (one cycle) |
| done_op | output | 9 | Operation field, valid with done |
| done_ac | output | 4 | Accumulator field, valid with done |
| done_ea | output | 18 | Effective address, valid with done |
| error | output | 1 | Unhandled operation, sticky |

## Verification
After `start` is sampled, the fetch read appears in the next cycle and `pc` advances two cycles later. `done` follows 3 + 2·N cycles after the start sample, where N is the number of index and indirect steps. `error` follows one cycle after a rejected done. The bench's reference model walks each address chain through its own copy of memory to find N and the expected address. It then compares `done` against the predicted cycle on every clock, sampling on the falling edge. The operation, accumulator, address and program counter are checked only in the predicted done cycle.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int OP_W   = 9;
  parameter int AC_W   = 4;
  parameter int X_W    = 4;
  parameter int ADDR_W = 18;
  localparam int WORD_W = OP_W + AC_W + 1 + X_W + ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic [AC_W-1:0] ac;
    logic            ind;
    logic [X_W-1:0]  idx;
    addr_t           addr;
  } instr_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_LOAD,
    S_RESOLVE,
    S_XWAIT,
    S_IWAIT,
    S_DONE,
    S_HANG
  } seq_state_t;

  function automatic addr_t ea_index_add(addr_t base, addr_t reg_low);
    return base + reg_low;
  endfunction

  function automatic addr_t ea_next_pc(addr_t cur);
    return cur + ADDR_W'(1);
  endfunction

  function automatic instr_t ea_split(word_t w);
    return instr_t'(w);
  endfunction
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_valid,
  input  logic idx_nz,
  input  logic ind_set,
  output logic fetch_rd,
  output logic ir_load,
  output logic x_rd,
  output logic x_add,
  output logic i_rd,
  output logic i_load,
  output logic done,
  output logic hang
);
  seq_state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start) state_d = S_FETCH;
      S_FETCH:   state_d = S_LOAD;
      S_LOAD:    state_d = S_RESOLVE;
      S_RESOLVE: begin
        if (idx_nz)       state_d = S_XWAIT;
        else if (ind_set) state_d = S_IWAIT;
        else              state_d = S_DONE;
      end
      S_XWAIT:   state_d = S_RESOLVE;
      S_IWAIT:   state_d = S_RESOLVE;
      S_DONE:    state_d = op_valid ? S_IDLE : S_HANG;
      S_HANG:    state_d = S_HANG;
      default:   state_d = S_IDLE;
    endcase
  end

  assign fetch_rd = (state_q == S_FETCH);
  assign ir_load  = (state_q == S_LOAD);
  assign x_rd     = (state_q == S_RESOLVE) && idx_nz;
  assign x_add    = (state_q == S_XWAIT);
  assign i_rd     = (state_q == S_RESOLVE) && !idx_nz && ind_set;
  assign i_load   = (state_q == S_IWAIT);
  assign done     = (state_q == S_DONE);
  assign hang     = (state_q == S_HANG);
endmodule

// File: rtl/ea_regs.sv
module ea_regs
  import ea_pkg::*;
#(
  parameter addr_t RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_load,
  input  logic            x_add,
  input  logic            i_load,
  input  word_t           mem_word,
  input  addr_t           reg_low,
  output addr_t           pc_q,
  output logic [OP_W-1:0] op_q,
  output logic [AC_W-1:0] ac_q,
  output logic            ind_q,
  output logic [X_W-1:0]  idx_q,
  output addr_t           ar_q
);
  instr_t fetched;
  assign fetched = ea_split(mem_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      op_q  <= '0;
      ac_q  <= '0;
      ind_q <= 1'b0;
      idx_q <= '0;
      ar_q  <= '0;
    end else if (ir_load) begin
      pc_q  <= ea_next_pc(pc_q);
      op_q  <= fetched.op;
      ac_q  <= fetched.ac;
      ind_q <= fetched.ind;
      idx_q <= fetched.idx;
      ar_q  <= fetched.addr;
    end else if (x_add) begin
      ar_q  <= ea_index_add(ar_q, reg_low);
      idx_q <= '0;
    end else if (i_load) begin
      ind_q <= fetched.ind;
      idx_q <= fetched.idx;
      ar_q  <= fetched.addr;
    end
  end
endmodule

// File: rtl/ea_port_mux.sv
module ea_port_mux
  import ea_pkg::*;
(
  input  logic           fetch_rd,
  input  logic           x_rd,
  input  logic           i_rd,
  input  addr_t          pc_q,
  input  addr_t          ar_q,
  input  logic [X_W-1:0] idx_q,
  output logic           mem_rd_en,
  output addr_t          mem_rd_addr,
  output logic           reg_rd_en,
  output logic [X_W-1:0] reg_rd_idx
);
  always_comb begin
    mem_rd_en   = fetch_rd | i_rd;
    mem_rd_addr = '0;
    if (fetch_rd)  mem_rd_addr = pc_q;
    else if (i_rd) mem_rd_addr = ar_q;
    reg_rd_en  = x_rd;
    reg_rd_idx = x_rd ? idx_q : '0;
  end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_valid,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              reg_rd_en,
  output logic [X_W-1:0]    reg_rd_idx,
  input  logic [ADDR_W-1:0] reg_rd_data,
  output logic [ADDR_W-1:0] pc,
  output logic              done,
  output logic [OP_W-1:0]   done_op,
  output logic [AC_W-1:0]   done_ac,
  output logic [ADDR_W-1:0] done_ea,
  output logic              error
);
  logic            fetch_rd, ir_load, x_rd, x_add, i_rd, i_load, hang;
  logic [OP_W-1:0] op_fld;
  logic [AC_W-1:0] ac_fld;
  logic            ind_fld;
  logic [X_W-1:0]  x_fld;
  addr_t           ar_fld;

  ea_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (op_valid),
    .idx_nz   (x_fld != '0),
    .ind_set  (ind_fld),
    .fetch_rd (fetch_rd),
    .ir_load  (ir_load),
    .x_rd     (x_rd),
    .x_add    (x_add),
    .i_rd     (i_rd),
    .i_load   (i_load),
    .done     (done),
    .hang     (hang)
  );

  ea_regs #(.RESET_PC(RESET_PC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_load  (ir_load),
    .x_add    (x_add),
    .i_load   (i_load),
    .mem_word (mem_rd_data),
    .reg_low  (reg_rd_data),
    .pc_q     (pc),
    .op_q     (op_fld),
    .ac_q     (ac_fld),
    .ind_q    (ind_fld),
    .idx_q    (x_fld),
    .ar_q     (ar_fld)
  );

  ea_port_mux u_mux (
    .fetch_rd    (fetch_rd),
    .x_rd        (x_rd),
    .i_rd        (i_rd),
    .pc_q        (pc),
    .ar_q        (ar_fld),
    .idx_q       (x_fld),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_idx  (reg_rd_idx)
  );

  assign done_op = done ? op_fld : '0;
  assign done_ac = done ? ac_fld : '0;
  assign done_ea = done ? ar_fld : '0;
  assign error   = hang;
endmodule

// File: rtl/ea_seq_checker.sv
module ea_seq_checker
  import ea_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            done,
  input logic            error,
  input logic            mem_rd_en,
  input logic            reg_rd_en,
  input logic [X_W-1:0]  reg_rd_idx,
  input addr_t           pc,
  input logic            ir_load,
  input logic            x_add,
  input logic            i_load,
  input logic [X_W-1:0]  x_fld,
  input logic [OP_W-1:0] op_fld,
  input logic [AC_W-1:0] ac_fld
);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> pc == $past(pc) + ADDR_W'(1));

  assert_idx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    x_add |=> x_fld == '0);

  assert_no_reg0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> reg_rd_idx != '0);

  assert_ind_keeps_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    i_load |=> (op_fld == $past(op_fld)) && (ac_fld == $past(ac_fld)));

  assert_index_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    i_load |-> x_fld == '0);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd_en && !reg_rd_en);

  assert_hang_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !mem_rd_en && !reg_rd_en);

  assert_hang_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(done) && !$past(op_valid));
endmodule

bind ea_sequencer ea_seq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .done       (done),
  .error      (error),
  .mem_rd_en  (mem_rd_en),
  .reg_rd_en  (reg_rd_en),
  .reg_rd_idx (reg_rd_idx),
  .pc         (pc),
  .ir_load    (ir_load),
  .x_add      (x_add),
  .i_load     (i_load),
  .x_fld      (x_fld),
  .op_fld     (op_fld),
  .ac_fld     (ac_fld)
);

// File: tb/ea_sequencer_tb.sv
module ea_sequencer_tb;
  localparam logic [17:0] START_PC = 18'h3FFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_valid = 1'b1;
  logic        mem_rd_en, reg_rd_en, done, error;
  logic [17:0] mem_rd_addr, pc, done_ea;
  logic [35:0] mem_rd_data = '0;
  logic [3:0]  reg_rd_idx, done_ac;
  logic [17:0] reg_rd_data = '0;
  logic [8:0]  done_op;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [17:0] exp_pc = START_PC;
  logic [35:0] mem [int];

  always #5 clk = ~clk;

  ea_sequencer #(.RESET_PC(START_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_valid(op_valid),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .reg_rd_en(reg_rd_en), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .pc(pc), .done(done), .done_op(done_op), .done_ac(done_ac),
    .done_ea(done_ea), .error(error)
  );

  function automatic logic [35:0] rd(int a);
    if (mem.exists(a)) return mem[a];
    return '0;
  endfunction

  // R3: op[35:27] ac[26:23] ind[22] idx[21:18] addr[17:0]
  function automatic logic [35:0] mk(int op, int ac, int ind, int x, int y);
    logic [35:0] w;
    w[35:27] = op[8:0];
    w[26:23] = ac[3:0];
    w[22]    = ind[0];
    w[21:18] = x[3:0];
    w[17:0]  = y[17:0];
    return w;
  endfunction

  // memory and accumulator-as-low-memory register port, one cycle latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rd_data <= rd(int'(mem_rd_addr));
    if (reg_rd_en) reg_rd_data <= rd(int'(reg_rd_idx))[17:0];
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // reference walk of one address chain
  task automatic ref_walk(input logic [35:0] w, output int e, output int steps);
    int x = int'(w[21:18]);
    int ind = int'(w[22]);
    int a = int'(w[17:0]);
    logic [35:0] f;
    steps = 0;
    forever begin
      if (x != 0) begin
        a = (a + int'(rd(x)[17:0])) % 262144;
        x = 0;
        steps++;
      end else if (ind != 0) begin
        f = rd(a);
        ind = int'(f[22]);
        x = int'(f[21:18]);
        a = int'(f[17:0]);
        steps++;
      end else break;
    end
    e = a;
  endtask

  task automatic run_instr(input string req, input logic ov, input bit poke);
    logic [35:0] w = rd(int'(exp_pc));
    int e, s, lat;
    ref_walk(w, e, s);
    lat = 3 + 2 * s;
    @(negedge clk); start = 1'b1; op_valid = ov;
    @(negedge clk); start = 1'b0;
    check("R2", "fetch read enable", mem_rd_en, 1);
    check("R2", "fetch address", mem_rd_addr, exp_pc);
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      start = (poke && n == 1);
      check(req, $sformatf("done at cycle %0d", n), done, (n == lat));
      if (n == lat) begin
        check(req, "op R3", done_op, w[35:27]);
        check(req, "ac R3", done_ac, w[26:23]);
        check(req, "effective address", done_ea, e);
        check("R11", "pc advanced", pc, 18'(exp_pc + 18'd1));
        check("R9", "no read in done cycle", mem_rd_en | reg_rd_en, 0);
      end
    end
    start = 1'b0;
    check("R10", "error after done", error, !ov);
    check("R9", "idle after done, no stray fetch", mem_rd_en, 0);
    exp_pc = 18'(exp_pc + 18'd1);
  endtask

  initial begin
    wait (cyc > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    // program: pc 3FFFE, 3FFFF, then wraps to 0..6
    mem[18'h3FFFE] = mk(9'o201, 1, 0, 0, 18'h00400);
    mem[18'h3FFFF] = mk(9'o202, 2, 0, 12, 18'h00100);
    mem[0] = mk(9'o203, 3, 0, 13, 18'h3FFF0);
    mem[1] = mk(9'o204, 4, 1, 0, 18'h01000);
    mem[2] = mk(9'o205, 5, 1, 0, 18'h01001);
    mem[3] = mk(9'o206, 6, 1, 0, 18'h01002);
    mem[4] = mk(9'o207, 7, 1, 12, 18'h00FF0);
    mem[5] = mk(9'o777, 15, 0, 0, 18'h00055);
    mem[6] = mk(9'o700, 8, 0, 0, 18'h00066);
    mem[12] = 36'hF_FFFC_0010;
    mem[13] = 36'h0_0000_0020;
    mem[14] = 36'h0_0000_0007;
    mem[18'h01000] = mk(9'h1FF, 15, 0, 0, 18'h02345);
    mem[18'h01001] = mk(0, 0, 0, 14, 18'h00200);
    mem[18'h01002] = mk(0, 0, 1, 0, 18'h01003);
    mem[18'h01003] = mk(0, 0, 0, 0, 18'h03333);

    repeat (3) @(negedge clk);
    check("R1", "done in reset", done, 0);
    check("R1", "error in reset", error, 0);
    check("R1", "pc in reset", pc, START_PC);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R1", "no read while idle", mem_rd_en | reg_rd_en, 0);
    end
    check("R1", "pc after reset", pc, START_PC);

    run_instr("R8", 1'b1, 1'b0);   // direct, E=0x400
    run_instr("R4", 1'b1, 1'b0);   // index, high register bits ignored, pc wraps R11
    check("R11", "pc wrapped to zero", pc, 0);
    run_instr("R4", 1'b1, 1'b0);   // index wraps address to 0x10
    run_instr("R6", 1'b1, 1'b0);   // single indirect, op/ac kept
    run_instr("R6", 1'b1, 1'b0);   // indirect to word that indexes: 0x207
    run_instr("R6", 1'b1, 1'b0);   // two-level chain: 0x3333
    run_instr("R7", 1'b1, 1'b0);   // index first then indirect: 0x2345
    run_instr("R9", 1'b1, 1'b1);   // start during resolve ignored
    check("R9", "pc not bumped by stray start", pc, 18'd6);
    run_instr("R10", 1'b0, 1'b0);  // rejected op -> hang
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R10", "hang ignores start", mem_rd_en, 0);
      check("R10", "error sticky", error, 1);
      check("R10", "no done in hang", done, 0);
    end
    check("R5", "register 0 never read", reg_rd_en && reg_rd_idx == 0, 0);
    finish_run();
  end
endmodule